// File: doc/BRIEF.md
# One-Time-Pad Line Encryption Unit

This unit sits between the last-level cache and external memory. Lines leave the chip encrypted on write-back and come back decrypted on fill. The cipher is a one-time pad. The pad is a keyed mixing function of the line's virtual address and a sequence number that belongs to that line. The key is the identifier of the program that owns the line. Ciphertext is plaintext XOR pad, and decryption applies the same XOR.

A small, fully associative on-chip table holds the current sequence number of recently written lines. Each entry is tagged with the line address and with the owning program identifier. On a fill that finds its sequence number in the table, the memory read and the pad pipeline start in the same cycle. When the data arrives, a single registered XOR finishes the job.

A line whose sequence number is not held falls back to a slow serial keyed cipher. This happens when the line was never written, belongs to another program, or could not be allocated because the table is full. On a fill, that cipher runs after the data returns. Entries are never evicted, so once the table is full, new lines stay on the slow path. Only one request is in flight at a time.

Top module: `otp_mem_crypt`

## Requirements
- R1: After reset, `c_req_ready` is 1 and both `c_rsp_valid` and `m_req_valid` are 0.
- R2: A line written back and then filled under the same program identifier returns the written plaintext.
- R3: The word sent to memory on a write-back differs from the plaintext.
- R4: Writing the same plaintext to the same line twice stores two different ciphertexts, because the line's sequence number advances on every write-back.
- R5: On a fill that hits the sequence table, the memory read is issued in the cycle after the request is accepted. The pad is already complete when the data arrives. `c_rsp_valid` rises exactly one cycle after `m_rsp_valid`.
- R6: Table entries match only the program identifier that created them. A fill of a line under a different identifier takes the slow path and does not yield the other program's plaintext.
- R7: A write-back that misses the table while a free entry exists allocates that entry. The write takes the fast path: the memory write is issued at most PAD_STAGES+3 cycles after acceptance, and later fills of that line take the fast path.
- R8: With every entry in use and no entry for the line, a write-back is encrypted by the slow cipher, so the memory write appears at least SLOW_LAT cycles after acceptance. The following fill decrypts serially, with `c_rsp_valid` at least SLOW_LAT cycles after `m_rsp_valid`, and still returns the plaintext. Entries are never evicted.
- R9: A fill of a line that was never written takes the slow path.
- R10: `c_req_ready` is 0 from acceptance until the response. `c_rsp_valid` and `m_req_valid` are single-cycle pulses.
- R11: A write-back is acknowledged on the cache side exactly one cycle after memory acknowledges the write, with `c_rsp_rdata` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_key | input | ID_W | Identifier of the running program; keys the pad and tags table entries |
| c_req_valid | input | 1 | Cache request strobe, taken when `c_req_ready` is 1 |
| c_req_ready | output | 1 | Unit idle and able to take a request |
| c_req_write | input | 1 | 1 = write-back, 0 = fill |
| c_req_addr | input | ADDR_W | Virtual byte address of the 64-bit line |
| c_req_wdata | input | 64 | Plaintext line for a write-back |
| c_rsp_valid | output | 1 | One-cycle response pulse |
| c_rsp_rdata | output | 64 | Plaintext on a fill, 0 on a write acknowledge |
| m_req_valid | output | 1 | One-cycle memory request pulse |
| m_req_write | output | 1 | 1 = memory write |
| m_req_addr | output | ADDR_W | Memory line address |
| m_req_wdata | output | 64 | Ciphertext for a memory write |
| m_rsp_valid | input | 1 | Memory response pulse (read data or write acknowledge) |
| m_rsp_rdata | input | 64 | Ciphertext returned by memory |

## Verification
Fill results are timed from the memory response. A table hit must produce `c_rsp_valid` exactly one cycle after `m_rsp_valid`. A slow fill must take at least SLOW_LAT cycles. Write-backs are timed from acceptance to the memory write: at most PAD_STAGES+3 cycles on the fast path and at least SLOW_LAT on the slow path. The bench samples every port on the falling edge and timestamps each event with a rising-edge cycle counter, so each delay is a difference of counts. The memory model answers a fixed ten cycles after each request.

// File: rtl/otp_pkg.sv
package otp_pkg;

   localparam int LINE_W   = 64;
   localparam int LINE_LSB = 3;
   localparam logic [63:0] GOLDEN = 64'h9E37_79B9_7F4A_7C15;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_PAD,
      ST_WR_SLOW,
      ST_WR_ACK,
      ST_RD_FAST,
      ST_RD_SLOW,
      ST_RD_DEC
   } ctl_state_t;

   function automatic logic [63:0] key_expand(input logic [63:0] k);
      return k ^ (k << 32) ^ 64'hA5C3_96E1_0F1E_2D3C;
   endfunction

   function automatic logic [63:0] make_seed(input logic [63:0] a, input logic [63:0] s);
      return a ^ (s << 40) ^ (s << 7);
   endfunction

   function automatic logic [63:0] mix_round(input logic [63:0] x, input logic [63:0] k,
                                             input int unsigned r);
      logic [63:0] t;
      t = x + (k ^ (GOLDEN * 64'(r + 1)));
      t = t ^ {t[50:0], t[63:51]};
      t = t ^ (t >> 17);
      return t;
   endfunction

   function automatic logic [63:0] full_mix(input logic [63:0] seed, input logic [63:0] k,
                                            input int unsigned rounds);
      logic [63:0] t;
      t = seed;
      for (int unsigned r = 0; r < rounds; r++) t = mix_round(t, k, r);
      return t;
   endfunction

endpackage

// File: rtl/otp_pad_gen.sv
module otp_pad_gen #(
   parameter int STAGES = 4,
   parameter int ADDR_W = 32,
   parameter int SEQ_W  = 16,
   parameter int ID_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEQ_W-1:0]  seq,
   input  logic [ID_W-1:0]   key,
   output logic              done,
   output logic [63:0]       pad
);
   import otp_pkg::*;

   if (STAGES < 1) begin : g_bad_stages
      $error("otp_pad_gen: STAGES must be at least 1");
   end

   logic [63:0] x_q [STAGES+1];
   logic [63:0] k_q [STAGES+1];
   logic        v_q [STAGES+1];

   always_comb begin
      x_q[0] = make_seed(64'(addr), 64'(seq));
      k_q[0] = key_expand(64'(key));
      v_q[0] = start;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[s+1] <= 1'b0;
            x_q[s+1] <= '0;
            k_q[s+1] <= '0;
         end else begin
            v_q[s+1] <= v_q[s];
            x_q[s+1] <= mix_round(x_q[s], k_q[s], s);
            k_q[s+1] <= k_q[s];
         end
      end
   end

   assign done = v_q[STAGES];
   assign pad  = x_q[STAGES];

endmodule

// File: rtl/otp_slow_cipher.sv
module otp_slow_cipher #(
   parameter int LAT    = 50,
   parameter int ROUNDS = 4,
   parameter int ADDR_W = 32,
   parameter int ID_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              decrypt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ID_W-1:0]   key,
   input  logic [63:0]       din,
   output logic              done,
   output logic [63:0]       dout
);
   import otp_pkg::*;

   localparam int CNT_W = $clog2(LAT + 1);
   localparam int ROT   = 13;

   if (LAT < 2) begin : g_bad_lat
      $error("otp_slow_cipher: LAT must be at least 2");
   end

   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic              dec_q;
   logic [63:0]       din_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ID_W-1:0]   key_q;
   logic [63:0]       blk_pad;
   logic [63:0]       result;

   always_comb begin
      blk_pad = full_mix(64'(addr_q), key_expand(64'(key_q)), ROUNDS);
      if (dec_q) result = {din_q[ROT-1:0], din_q[63:ROT]} ^ blk_pad;
      else begin
         result = din_q ^ blk_pad;
         result = {result[63-ROT:0], result[63:64-ROT]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
         dout   <= '0;
         dec_q  <= 1'b0;
         din_q  <= '0;
         addr_q <= '0;
         key_q  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(LAT - 1);
            dec_q  <= decrypt;
            din_q  <= din;
            addr_q <= addr;
            key_q  <= key;
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
               dout <= result;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R8
   slow_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R8
   slow_done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/otp_seq_cache.sv
module otp_seq_cache #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 29,
   parameter int SEQ_W   = 16,
   parameter int ID_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] look_tag,
   input  logic [ID_W-1:0]  look_id,
   input  logic             upd_en,
   output logic             hit,
   output logic             has_free,
   output logic [SEQ_W-1:0] cur_seq,
   output logic [SEQ_W-1:0] next_seq
);

   if (ENTRIES < 1) begin : g_bad_entries
      $error("otp_seq_cache: ENTRIES must be at least 1");
   end

   logic [ENTRIES-1:0] valid;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] alloc_sel;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ID_W-1:0]    own_q [ENTRIES];
   logic [SEQ_W-1:0]   seq_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match[i] = valid[i] && (tag_q[i] == look_tag) && (own_q[i] == look_id);
   end

   always_comb begin
      logic found;
      found     = 1'b0;
      alloc_sel = '0;
      cur_seq   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) cur_seq = cur_seq | seq_q[i];
         if (!valid[i] && !found) begin
            alloc_sel[i] = 1'b1;
            found        = 1'b1;
         end
      end
   end

   assign hit      = |match;
   assign has_free = ~&valid;
   assign next_seq = hit ? cur_seq + 1'b1 : SEQ_W'(1);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid[i] <= 1'b0;
            tag_q[i] <= '0;
            own_q[i] <= '0;
            seq_q[i] <= '0;
         end else if (upd_en) begin
            if (match[i]) begin
               seq_q[i] <= seq_q[i] + 1'b1;
            end else if (!hit && alloc_sel[i]) begin
               valid[i] <= 1'b1;
               tag_q[i] <= look_tag;
               own_q[i] <= look_id;
               seq_q[i] <= SEQ_W'(1);
            end
         end
      end
   end

   // R6
   snc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8
   snc_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(valid) >= $past($countones(valid))));

   // R4
   snc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && hit) |=> ($countones(valid) == $past($countones(valid))));

endmodule

// File: rtl/otp_mem_crypt.sv
module otp_mem_crypt #(
   parameter int ADDR_W     = 32,
   parameter int SEQ_W      = 16,
   parameter int ID_W       = 16,
   parameter int ENTRIES    = 4,
   parameter int PAD_STAGES = 4,
   parameter int SLOW_LAT   = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   prog_key,
   input  logic              c_req_valid,
   output logic              c_req_ready,
   input  logic              c_req_write,
   input  logic [ADDR_W-1:0] c_req_addr,
   input  logic [63:0]       c_req_wdata,
   output logic              c_rsp_valid,
   output logic [63:0]       c_rsp_rdata,
   output logic              m_req_valid,
   output logic              m_req_write,
   output logic [ADDR_W-1:0] m_req_addr,
   output logic [63:0]       m_req_wdata,
   input  logic              m_rsp_valid,
   input  logic [63:0]       m_rsp_rdata
);
   import otp_pkg::*;

   localparam int TAG_W = ADDR_W - LINE_LSB;

   if (ADDR_W <= LINE_LSB || ADDR_W > 64) begin : g_bad_addr
      $error("otp_mem_crypt: ADDR_W out of range");
   end
   if (SEQ_W < 2 || SEQ_W > 24) begin : g_bad_seq
      $error("otp_mem_crypt: SEQ_W must lie in 2..24");
   end
   if (ID_W < 1 || ID_W > 32) begin : g_bad_id
      $error("otp_mem_crypt: ID_W must lie in 1..32");
   end

   ctl_state_t        st;
   logic [ADDR_W-1:0] addr_q;
   logic [63:0]       data_q;
   logic [ID_W-1:0]   key_q;
   logic [SEQ_W-1:0]  pad_seq_q;
   logic              pad_start_q;
   logic [63:0]       pad_q;
   logic              pad_have;
   logic              slow_start_q;
   logic              slow_dec_q;
   logic [63:0]       slow_din_q;

   logic              snc_hit, snc_free, snc_upd;
   logic [SEQ_W-1:0]  snc_cur, snc_next;
   logic              pad_done;
   logic [63:0]       pad_out;
   logic              slow_done;
   logic [63:0]       slow_out;
   logic              accept;

   assign c_req_ready = (st == ST_IDLE);
   assign accept      = c_req_ready && c_req_valid;
   assign snc_upd     = accept && c_req_write && (snc_hit || snc_free);

   otp_seq_cache #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .ID_W(ID_W)
   ) u_snc (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_tag (c_req_addr[ADDR_W-1:LINE_LSB]),
      .look_id  (prog_key),
      .upd_en   (snc_upd),
      .hit      (snc_hit),
      .has_free (snc_free),
      .cur_seq  (snc_cur),
      .next_seq (snc_next)
   );

   otp_pad_gen #(
      .STAGES(PAD_STAGES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .ID_W(ID_W)
   ) u_pad (
      .clk   (clk),
      .rst_n (rst_n),
      .start (pad_start_q),
      .addr  (addr_q),
      .seq   (pad_seq_q),
      .key   (key_q),
      .done  (pad_done),
      .pad   (pad_out)
   );

   otp_slow_cipher #(
      .LAT(SLOW_LAT), .ROUNDS(PAD_STAGES), .ADDR_W(ADDR_W), .ID_W(ID_W)
   ) u_slow (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (slow_start_q),
      .decrypt (slow_dec_q),
      .addr    (addr_q),
      .key     (key_q),
      .din     (slow_din_q),
      .done    (slow_done),
      .dout    (slow_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         addr_q       <= '0;
         data_q       <= '0;
         key_q        <= '0;
         pad_seq_q    <= '0;
         pad_start_q  <= 1'b0;
         pad_q        <= '0;
         pad_have     <= 1'b0;
         slow_start_q <= 1'b0;
         slow_dec_q   <= 1'b0;
         slow_din_q   <= '0;
         c_rsp_valid  <= 1'b0;
         c_rsp_rdata  <= '0;
         m_req_valid  <= 1'b0;
         m_req_write  <= 1'b0;
         m_req_addr   <= '0;
         m_req_wdata  <= '0;
      end else begin
         c_rsp_valid  <= 1'b0;
         m_req_valid  <= 1'b0;
         pad_start_q  <= 1'b0;
         slow_start_q <= 1'b0;
         if (pad_done) begin
            pad_q    <= pad_out;
            pad_have <= 1'b1;
         end
         unique case (st)
            ST_IDLE: if (c_req_valid) begin
               addr_q   <= c_req_addr;
               data_q   <= c_req_wdata;
               key_q    <= prog_key;
               pad_have <= 1'b0;
               if (c_req_write) begin
                  if (snc_hit || snc_free) begin
                     pad_start_q <= 1'b1;
                     pad_seq_q   <= snc_next;
                     st          <= ST_WR_PAD;
                  end else begin
                     slow_start_q <= 1'b1;
                     slow_dec_q   <= 1'b0;
                     slow_din_q   <= c_req_wdata;
                     st           <= ST_WR_SLOW;
                  end
               end else begin
                  m_req_valid <= 1'b1;
                  m_req_write <= 1'b0;
                  m_req_addr  <= c_req_addr;
                  if (snc_hit) begin
                     pad_start_q <= 1'b1;
                     pad_seq_q   <= snc_cur;
                     st          <= ST_RD_FAST;
                  end else begin
                     st <= ST_RD_SLOW;
                  end
               end
            end
            ST_WR_PAD: if (pad_done) begin
               m_req_valid <= 1'b1;
               m_req_write <= 1'b1;
               m_req_addr  <= addr_q;
               m_req_wdata <= data_q ^ pad_out;
               st          <= ST_WR_ACK;
            end
            ST_WR_SLOW: if (slow_done) begin
               m_req_valid <= 1'b1;
               m_req_write <= 1'b1;
               m_req_addr  <= addr_q;
               m_req_wdata <= slow_out;
               st          <= ST_WR_ACK;
            end
            ST_WR_ACK: if (m_rsp_valid) begin
               c_rsp_valid <= 1'b1;
               c_rsp_rdata <= '0;
               st          <= ST_IDLE;
            end
            ST_RD_FAST: if (m_rsp_valid) begin
               c_rsp_valid <= 1'b1;
               c_rsp_rdata <= m_rsp_rdata ^ pad_q;
               st          <= ST_IDLE;
            end
            ST_RD_SLOW: if (m_rsp_valid) begin
               slow_start_q <= 1'b1;
               slow_dec_q   <= 1'b1;
               slow_din_q   <= m_rsp_rdata;
               st           <= ST_RD_DEC;
            end
            ST_RD_DEC: if (slow_done) begin
               c_rsp_valid <= 1'b1;
               c_rsp_rdata <= slow_out;
               st          <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R5
   rd_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !c_req_write) |=> (m_req_valid && !m_req_write));

   // R5
   pad_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_FAST && m_rsp_valid) |-> pad_have);

   // R5
   xor_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_FAST && m_rsp_valid) |=> c_rsp_valid);

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_rsp_valid |=> !c_rsp_valid);

   // R10
   mreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_valid |=> !m_req_valid);

   // R11
   wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR_ACK && m_rsp_valid) |=> (c_rsp_valid && c_rsp_rdata == '0));

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !c_req_ready);

endmodule

// File: tb/otp_mem_crypt_test.sv
module otp_mem_crypt_test;

   localparam int SLOW    = 50;
   localparam int STAGES  = 4;
   localparam int MEM_LAT = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] prog_key = '0;
   logic        c_req_valid = 1'b0;
   logic        c_req_ready;
   logic        c_req_write = 1'b0;
   logic [31:0] c_req_addr = '0;
   logic [63:0] c_req_wdata = '0;
   logic        c_rsp_valid;
   logic [63:0] c_rsp_rdata;
   logic        m_req_valid;
   logic        m_req_write;
   logic [31:0] m_req_addr;
   logic [63:0] m_req_wdata;
   logic        m_rsp_valid = 1'b0;
   logic [63:0] m_rsp_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   logic [63:0] mem [64];

   otp_mem_crypt #(
      .ADDR_W(32), .SEQ_W(16), .ID_W(16), .ENTRIES(4),
      .PAD_STAGES(STAGES), .SLOW_LAT(SLOW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .prog_key(prog_key),
      .c_req_valid(c_req_valid), .c_req_ready(c_req_ready),
      .c_req_write(c_req_write), .c_req_addr(c_req_addr), .c_req_wdata(c_req_wdata),
      .c_rsp_valid(c_rsp_valid), .c_rsp_rdata(c_rsp_rdata),
      .m_req_valid(m_req_valid), .m_req_write(m_req_write),
      .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
      .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata)
   );

   always #4 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // memory model: answers MEM_LAT cycles after each request
   initial begin
      int cnt;
      logic [5:0] idx;
      cnt = 0;
      idx = '0;
      for (int i = 0; i < 64; i++) mem[i] = 64'h5EED_0000_0000_0000 | 64'(i);
      forever begin
         @(posedge clk);
         #1;
         m_rsp_valid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               m_rsp_valid = 1'b1;
               m_rsp_rdata = mem[idx];
            end
         end
         if (m_req_valid) begin
            idx = m_req_addr[8:3];
            if (m_req_write) mem[idx] = m_req_wdata;
            cnt = MEM_LAT;
         end
      end
   end

   typedef struct packed {
      logic        wr;
      logic [15:0] key;
      logic [5:0]  line;
      logic [63:0] data;
      logic        fast;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0011, 6'd0, 64'h0123_4567_89AB_CDEF, 1'b1},
      '{1'b0, 16'h0011, 6'd0, 64'h0123_4567_89AB_CDEF, 1'b1},
      '{1'b1, 16'h0011, 6'd1, 64'hFFFF_0000_FFFF_0000, 1'b1},
      '{1'b0, 16'h0011, 6'd1, 64'hFFFF_0000_FFFF_0000, 1'b1},
      '{1'b1, 16'h0011, 6'd2, 64'h0000_0000_0000_0000, 1'b1},
      '{1'b1, 16'h0011, 6'd3, 64'hDEAD_BEEF_CAFE_F00D, 1'b1},
      '{1'b0, 16'h0011, 6'd2, 64'h0000_0000_0000_0000, 1'b1},
      '{1'b1, 16'h0011, 6'd4, 64'h1357_9BDF_2468_ACE0, 1'b0},
      '{1'b0, 16'h0011, 6'd4, 64'h1357_9BDF_2468_ACE0, 1'b0},
      '{1'b0, 16'h0011, 6'd3, 64'hDEAD_BEEF_CAFE_F00D, 1'b1}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic wr, input logic [15:0] k, input logic [5:0] ln,
                        input logic [63:0] d, output logic [63:0] rd,
                        output int d_req, output int d_rsp);
      int t0, tq, tm;
      bit busy_ok;
      @(negedge clk);
      while (!c_req_ready) @(negedge clk);
      c_req_valid = 1'b1;
      c_req_write = wr;
      c_req_addr  = {23'd0, ln, 3'b000};
      c_req_wdata = d;
      prog_key    = k;
      t0 = cyc;
      @(negedge clk);
      c_req_valid = 1'b0;
      tq = -1;
      tm = -1;
      busy_ok = 1;
      forever begin
         if (m_req_valid && tq < 0) tq = cyc;
         if (m_rsp_valid) tm = cyc;
         if (c_rsp_valid) break;
         if (c_req_ready) busy_ok = 0;
         @(negedge clk);
      end
      rd    = c_rsp_rdata;
      d_req = tq - t0;
      d_rsp = cyc - tm;
      // R10 ready held low while busy
      check(busy_ok, "R10 ready low while busy", 64'(busy_ok), 64'd1);
      @(negedge clk);
      // R10 response is one cycle wide
      check(!c_rsp_valid, "R10 rsp pulse width", 64'(c_rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd, c1, c2;
      int dq, dr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(c_req_ready && !c_rsp_valid && !m_req_valid, "R1 reset outputs",
            {61'd0, c_req_ready, c_rsp_valid, m_req_valid}, 64'd4);
      rst_n = 1'b1;
      @(negedge clk);
      check(c_req_ready && !c_rsp_valid && !m_req_valid, "R1 idle after reset",
            {61'd0, c_req_ready, c_rsp_valid, m_req_valid}, 64'd4);

      for (int v = 0; v < NV; v++) begin
         do_op(VECS[v].wr, VECS[v].key, VECS[v].line, VECS[v].data, rd, dq, dr);
         if (VECS[v].wr) begin
            // R3 memory holds ciphertext
            check(mem[VECS[v].line] != VECS[v].data, "R3 stored word is not plaintext",
                  mem[VECS[v].line], ~VECS[v].data);
            // R11 write acknowledge
            check(dr == 1 && rd == 64'd0, "R11 write ack one cycle after memory",
                  {32'(dr), rd[31:0]}, {32'd1, 32'd0});
            if (VECS[v].fast)
               // R7 allocated or hit write uses the pad path
               check(dq >= 1 && dq <= STAGES + 3, "R7 fast write issue delay",
                     64'(dq), 64'(STAGES + 3));
            else
               // R8 full table forces slow encryption
               check(dq >= SLOW, "R8 slow write issue delay", 64'(dq), 64'(SLOW));
         end else begin
            // R2 round trip returns plaintext
            check(rd == VECS[v].data, "R2 fill returns plaintext", rd, VECS[v].data);
            if (VECS[v].fast) begin
               // R5 memory read issued next cycle, XOR one cycle after data
               check(dq == 1, "R5 read issued at once", 64'(dq), 64'd1);
               check(dr == 1, "R5 one-cycle XOR after data", 64'(dr), 64'd1);
            end else
               // R8 slow decrypt after data
               check(dr >= SLOW, "R8 serial decrypt delay", 64'(dr), 64'(SLOW));
         end
      end

      // R4 second write-back of same plaintext gets a fresh pad
      c1 = mem[0];
      do_op(1'b1, 16'h0011, 6'd0, 64'h0123_4567_89AB_CDEF, rd, dq, dr);
      c2 = mem[0];
      check(c2 != c1, "R4 ciphertext changes on rewrite", c2, ~c1);
      do_op(1'b0, 16'h0011, 6'd0, 64'h0, rd, dq, dr);
      check(rd == 64'h0123_4567_89AB_CDEF && dr == 1, "R4 R2 rewrite reads back fast",
            rd, 64'h0123_4567_89AB_CDEF);

      // R6 another program's identifier does not match the entry
      do_op(1'b0, 16'h0022, 6'd0, 64'h0, rd, dq, dr);
      check(dr >= SLOW, "R6 foreign id takes slow path", 64'(dr), 64'(SLOW));
      check(rd != 64'h0123_4567_89AB_CDEF, "R6 foreign id gets no plaintext",
            rd, ~64'h0123_4567_89AB_CDEF);

      // R9 never-written line is slow
      do_op(1'b0, 16'h0011, 6'd9, 64'h0, rd, dq, dr);
      check(dr >= SLOW, "R9 unwritten line slow", 64'(dr), 64'(SLOW));

      // R8 no eviction: line 4 still slow after another fill
      do_op(1'b1, 16'h0011, 6'd4, 64'h0F0F_0F0F_0F0F_0F0F, rd, dq, dr);
      check(dq >= SLOW, "R8 line stays on slow path", 64'(dq), 64'(SLOW));
      do_op(1'b0, 16'h0011, 6'd4, 64'h0, rd, dq, dr);
      check(rd == 64'h0F0F_0F0F_0F0F_0F0F, "R8 R2 slow round trip", rd,
            64'h0F0F_0F0F_0F0F_0F0F);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule